// File: doc/BRIEF.md
# Legacy Reset and A20 Control

This block holds two byte-wide system control registers on a simple I/O bus. The fast control register sits at its own I/O address. It sets the level of an alternate A20 gate output. It starts a fixed-length CPU INIT pulse when software raises its trigger bit. It also holds a sticky lock bit that other logic uses to guard protected RTC storage. The reset control register sits at a second address. It holds a reset-type select bit and a trigger bit. Raising the trigger produces a one-cycle hard-reset or soft-reset request, chosen by the select bit.

Writes are taken on any clock edge where the write strobe is high and the address matches. Read data is combinational: it is valid while the read strobe is high and zero otherwise. The reset input is asynchronous and active low. Its release is synchronised inside the block, so writes are ignored until the third clock edge after the release.

Top module: `legacy_sysctl`

## Requirements
- R1: While reset is asserted, and until two clock edges after its release, both registers hold 00h and all five control outputs are low.
- R2: A read of the fast control register returns stored bits 3, 1 and 0 in those positions. Bits 7:4 and bit 2 always read 0.
- R3: `a20_alt` is driven from the cycle after a fast-register write and equals the written bit 1 (0 low, 1 high).
- R4: A write that takes fast-register bit 0 from 0 to 1 drives `cpu_init` high for exactly INIT_LEN (16) cycles, starting the cycle after the write.
- R5: Writing 1 to bit 0 while it already holds 1 starts no pulse. The trigger is re-armed only by writing bit 0 back to 0.
- R6: A 0-to-1 write of bit 0 while a pulse is running is ignored: the pulse is neither restarted nor lengthened. The written value is still stored and read back.
- R7: Writing 1 to bit 3 sets `pw_lock`. Writing 0 does not clear it; only reset does.
- R8: A read of the reset control register returns the select bit in bit 1 and the trigger bit in bit 2. All other bits read 0.
- R9: A write that takes reset-control bit 2 from 0 to 1 with bit 1 = 1 pulses `hard_rst_req` for one cycle, the cycle after the write, with no soft request.
- R10: The same rising write with bit 1 = 0 pulses `soft_rst_req` for one cycle, with no hard request.
- R11: Writing bit 2 = 1 while it already holds 1 produces no reset request.
- R12: Writes to other addresses change nothing. Reads of other addresses, and any cycle with the read strobe low, return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| io_addr | input | ADDR_W | I/O address |
| io_wdata | input | 8 | Write data byte |
| io_wr | input | 1 | Write strobe, sampled on the clock edge |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data, zero when not selected |
| a20_alt | output | 1 | Alternate A20 gate level |
| cpu_init | output | 1 | Active-high CPU INIT pulse |
| hard_rst_req | output | 1 | One-cycle hard-reset request |
| soft_rst_req | output | 1 | One-cycle soft-reset request |
| pw_lock | output | 1 | Sticky power-on password lock flag |

## Verification
The bench repeats a 1 on the INIT trigger to show that a level-triggered design would fire a second pulse. It re-triggers in the middle of a pulse to catch a counter that reloads and stretches INIT beyond 16 cycles. Each pulse is compared cycle by cycle, so a pulse of 15 or 17 cycles shows up as a mismatch at its edge. It writes 0 over a set lock bit to expose a plain read/write lock, and it repeats a reset-control trigger to catch a request that fires on level. A final set of writes and reads to a neighbouring address catches loose address decoding.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  // fast control register bit positions (software-visible)
  localparam int FAST_INIT_BIT = 0;
  localparam int FAST_A20_BIT  = 1;
  localparam int FAST_LOCK_BIT = 3;
  // reset control register bit positions (software-visible)
  localparam int RC_SEL_BIT    = 1;
  localparam int RC_GO_BIT     = 2;

  typedef struct packed {
    logic lock;
    logic a20;
    logic init;
  } fast_t;
endpackage

// File: rtl/lsc_fast_reg.sv
module lsc_fast_reg
  import lsc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  logic  init_in,
  input  logic  a20_in,
  input  logic  lock_in,
  output fast_t q,
  output logic  init_rise
);
  fast_t d;

  always_comb begin
    d      = q;
    d.init = init_in;
    d.a20  = a20_in;
    d.lock = q.lock | lock_in;  // set-only; cleared by reset alone
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (wr_en) begin
      q <= d;
    end
  end

  assign init_rise = wr_en & init_in & ~q.init;
endmodule

// File: rtl/lsc_init_pulse.sv
module lsc_init_pulse #(
  parameter int LEN   = 16,
  localparam int CNT_W = $clog2(LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (cnt_q != '0) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end else if (fire) begin
      cnt_d  = CNT_W'(LEN);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign pulse = (cnt_q != '0);
endmodule

// File: rtl/lsc_rst_ctl.sv
module lsc_rst_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic sel_in,
  input  logic go_in,
  output logic sel_q,
  output logic go_q,
  output logic hard_req,
  output logic soft_req
);
  logic go_rise;
  logic hard_d, soft_d;

  always_comb begin
    go_rise = wr_en & go_in & ~go_q;
    hard_d  = go_rise & sel_in;
    soft_d  = go_rise & ~sel_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      go_q  <= 1'b0;
    end else if (wr_en) begin
      sel_q <= sel_in;
      go_q  <= go_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hard_req <= 1'b0;
      soft_req <= 1'b0;
    end else begin
      hard_req <= hard_d;
      soft_req <= soft_d;
    end
  end
endmodule

// File: rtl/legacy_sysctl.sv
module legacy_sysctl
  import lsc_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] FAST_ADDR = 16'h0092,
  parameter logic [ADDR_W-1:0] RSTC_ADDR = 16'h0CF9,
  parameter int                INIT_LEN  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic [7:0]        io_rdata,
  output logic              a20_alt,
  output logic              cpu_init,
  output logic              hard_rst_req,
  output logic              soft_rst_req,
  output logic              pw_lock
);
  logic  rst_meta_n, rst_q_n;
  logic  hit_fast, hit_rstc, wr_fast, wr_rstc;
  fast_t fast_q;
  logic  init_rise;
  logic  sel_q, go_q;
  logic  wdata_unused;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  always_comb begin
    hit_fast = (io_addr == FAST_ADDR);
    hit_rstc = (io_addr == RSTC_ADDR);
    wr_fast  = io_wr & hit_fast;
    wr_rstc  = io_wr & hit_rstc;
  end

  assign wdata_unused = ^io_wdata[7:4];

  lsc_fast_reg u_fast (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .wr_en     (wr_fast),
    .init_in   (io_wdata[FAST_INIT_BIT]),
    .a20_in    (io_wdata[FAST_A20_BIT]),
    .lock_in   (io_wdata[FAST_LOCK_BIT]),
    .q         (fast_q),
    .init_rise (init_rise)
  );

  lsc_init_pulse #(.LEN(INIT_LEN)) u_pulse (
    .clk   (clk),
    .rst_n (rst_q_n),
    .fire  (init_rise),
    .pulse (cpu_init)
  );

  lsc_rst_ctl u_rctl (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .wr_en    (wr_rstc),
    .sel_in   (io_wdata[RC_SEL_BIT]),
    .go_in    (io_wdata[RC_GO_BIT]),
    .sel_q    (sel_q),
    .go_q     (go_q),
    .hard_req (hard_rst_req),
    .soft_req (soft_rst_req)
  );

  always_comb begin
    io_rdata = 8'h00;
    if (io_rd && hit_fast) begin
      io_rdata[FAST_INIT_BIT] = fast_q.init;
      io_rdata[FAST_A20_BIT]  = fast_q.a20;
      io_rdata[FAST_LOCK_BIT] = fast_q.lock;
    end else if (io_rd && hit_rstc) begin
      io_rdata[RC_SEL_BIT] = sel_q;
      io_rdata[RC_GO_BIT]  = go_q;
    end
  end

  assign a20_alt = fast_q.a20;
  assign pw_lock = fast_q.lock;
endmodule

// File: rtl/lsc_checker.sv
module lsc_checker #(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] FAST_ADDR = 16'h0092,
  parameter int                INIT_LEN  = 16,
  localparam int RUN_W = $clog2(INIT_LEN + 2)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic [7:0]        io_wdata,
  input logic              io_wr,
  input logic              io_rd,
  input logic [7:0]        io_rdata,
  input logic              a20_alt,
  input logic              cpu_init,
  input logic              hard_rst_req,
  input logic              soft_rst_req,
  input logic              pw_lock
);
  logic [RUN_W-1:0] run_q;
  logic             chk_unused;

  assign chk_unused = ^{io_wdata[7:2], io_wdata[0]};

  // length of the current high run of cpu_init, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (!cpu_init) begin
      run_q <= '0;
    end else if (run_q != {RUN_W{1'b1}}) begin
      run_q <= run_q + 1'b1;
    end
  end

  assert_init_not_long_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_init |-> (run_q < RUN_W'(INIT_LEN)));

  assert_init_full_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_init && run_q != '0) |-> (run_q == RUN_W'(INIT_LEN)));

  assert_a20_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == FAST_ADDR) |=> (a20_alt == $past(io_wdata[1])));

  assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pw_lock |=> pw_lock);

  assert_req_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(hard_rst_req && soft_rst_req));

  assert_hard_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hard_rst_req |=> !hard_rst_req);

  assert_soft_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_req |=> !soft_rst_req);

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == FAST_ADDR) |-> (io_rdata[7:4] == 4'h0 && !io_rdata[2]));
endmodule

bind legacy_sysctl lsc_checker #(
  .ADDR_W(ADDR_W), .FAST_ADDR(FAST_ADDR), .INIT_LEN(INIT_LEN)
) u_chk (
  .clk(clk), .rst_n(rst_q_n), .io_addr(io_addr), .io_wdata(io_wdata),
  .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .a20_alt(a20_alt),
  .cpu_init(cpu_init), .hard_rst_req(hard_rst_req),
  .soft_rst_req(soft_rst_req), .pw_lock(pw_lock)
);

// File: tb/sim_legacy_sysctl.sv
module sim_legacy_sysctl;
  localparam logic [15:0] FAST = 16'h0092;
  localparam logic [15:0] RSTC = 16'h0CF9;
  localparam logic [15:0] OTHR = 16'h0093;

  typedef struct {
    logic [12:0] exp;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] io_addr;
  logic [7:0]  io_wdata;
  logic        io_wr, io_rd;
  logic [7:0]  io_rdata;
  logic        a20_alt, cpu_init, hard_rst_req, soft_rst_req, pw_lock;

  item_t sb_q[$];
  int    n_run  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;

  // reference model state
  logic       m_s1, m_s2, m_a20, m_ib, m_lock, m_sel, m_go, m_hard, m_soft;
  int         m_cnt;

  always #4 clk = ~clk;  // 125 MHz

  legacy_sysctl u0 (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .a20_alt(a20_alt),
    .cpu_init(cpu_init), .hard_rst_req(hard_rst_req),
    .soft_rst_req(soft_rst_req), .pw_lock(pw_lock)
  );

  task automatic model_reset();
    m_s1 = 0; m_s2 = 0; m_a20 = 0; m_ib = 0; m_lock = 0;
    m_sel = 0; m_go = 0; m_hard = 0; m_soft = 0; m_cnt = 0;
  endtask

  // state change at a clock edge, from the inputs held during the last cycle
  task automatic model_edge();
    logic wf, wr_r, rise_go, fire;
    if (!rst_n) begin
      model_reset();
    end else if (!m_s2) begin
      m_s2 = m_s1; m_s1 = 1;
    end else begin
      wf      = io_wr && io_addr == FAST;
      wr_r    = io_wr && io_addr == RSTC;
      rise_go = wr_r && io_wdata[2] && !m_go;
      fire    = wf && io_wdata[0] && !m_ib;
      m_hard  = rise_go && io_wdata[1];
      m_soft  = rise_go && !io_wdata[1];
      if (m_cnt != 0) m_cnt = m_cnt - 1;
      else if (fire)  m_cnt = 16;
      if (wf) begin
        m_a20 = io_wdata[1]; m_ib = io_wdata[0]; m_lock = m_lock | io_wdata[3];
      end
      if (wr_r) begin
        m_sel = io_wdata[1]; m_go = io_wdata[2];
      end
    end
  endtask

  function automatic logic [7:0] model_rd();
    if (io_rd && io_addr == FAST) return {4'h0, m_lock, 1'b0, m_a20, m_ib};
    if (io_rd && io_addr == RSTC) return {5'h00, m_go, m_sel, 1'b0};
    return 8'h00;
  endfunction

  // driver: one bus cycle, pushes the expected outputs for that cycle
  task automatic step(input logic rst, input logic [15:0] a, input logic [7:0] d,
                      input logic w, input logic r, input string req);
    item_t it;
    @(posedge clk);
    model_edge();
    #1;
    rst_n = rst; io_addr = a; io_wdata = d; io_wr = w; io_rd = r;
    if (!rst_n) model_reset();
    it.exp = {model_rd(), m_a20, (m_cnt != 0), m_hard, m_soft, m_lock};
    it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input string req);
    step(1'b1, a, d, 1'b1, 1'b0, req);
  endtask
  task automatic rd(input logic [15:0] a, input string req);
    step(1'b1, a, 8'h00, 1'b0, 1'b1, req);
  endtask
  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) step(1'b1, FAST, 8'h00, 1'b0, 1'b0, req);
  endtask
  task automatic do_reset(input string req);
    for (int i = 0; i < 3; i++) step(1'b0, FAST, 8'hFF, 1'b1, 1'b0, req);
    step(1'b0, RSTC, 8'h00, 1'b0, 1'b1, req);
    step(1'b1, FAST, 8'hFF, 1'b1, 1'b0, req);  // ignored during release
    idle(3, req);
  endtask

  // monitor: compares mid-cycle, away from the active edge
  always @(negedge clk) begin
    item_t it;
    logic [12:0] act;
    if (sb_q.size() > 0) begin
      it  = sb_q.pop_front();
      act = {io_rdata, a20_alt, cpu_init, hard_rst_req, soft_rst_req, pw_lock};
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: outputs {rdata,a20,init,hard,soft,lock} actual %h expected %h",
                 it.req, act, it.exp);
      end
    end
  end

  initial begin
    #1600000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; io_addr = FAST; io_wdata = 0; io_wr = 0; io_rd = 0;
    model_reset();
    do_reset("R1");
    rd(FAST, "R1"); rd(RSTC, "R1");
    // A20 and reserved bits
    wr(FAST, 8'hF2, "R3"); rd(FAST, "R2");
    wr(FAST, 8'h04, "R3"); rd(FAST, "R2");
    wr(FAST, 8'h02, "R3"); idle(2, "R3");
    // INIT pulse
    wr(FAST, 8'h01, "R4"); idle(20, "R4"); rd(FAST, "R4");
    wr(FAST, 8'h01, "R5"); idle(20, "R5");
    wr(FAST, 8'h00, "R5"); wr(FAST, 8'h01, "R5"); idle(5, "R5");
    wr(FAST, 8'h00, "R6"); rd(FAST, "R6"); wr(FAST, 8'h01, "R6"); rd(FAST, "R6");
    idle(20, "R6");
    wr(FAST, 8'h00, "R6"); wr(FAST, 8'h03, "R6"); idle(20, "R6");
    // lock
    wr(FAST, 8'h08, "R7"); rd(FAST, "R7");
    wr(FAST, 8'h00, "R7"); rd(FAST, "R7"); idle(2, "R7");
    do_reset("R7"); rd(FAST, "R7");
    // reset control
    wr(RSTC, 8'h02, "R8"); rd(RSTC, "R8"); idle(2, "R8");
    wr(RSTC, 8'h06, "R9"); idle(3, "R9");
    wr(RSTC, 8'h06, "R11"); wr(RSTC, 8'h04, "R11"); idle(3, "R11");
    wr(RSTC, 8'h00, "R10"); wr(RSTC, 8'h04, "R10"); idle(3, "R10");
    wr(RSTC, 8'hFF, "R8"); rd(RSTC, "R8"); idle(2, "R8");
    wr(RSTC, 8'h00, "R9"); wr(RSTC, 8'hFE, "R9"); idle(3, "R9");
    // unmapped address and idle read strobe
    wr(OTHR, 8'hFF, "R12"); idle(3, "R12"); rd(OTHR, "R12");
    wr(FAST, 8'h0B, "R12");
    step(1'b1, FAST, 8'h00, 1'b0, 1'b0, "R12");
    step(1'b1, RSTC, 8'h00, 1'b0, 1'b0, "R12");
    rd(FAST, "R12"); idle(20, "R12");
    @(posedge clk); @(negedge clk); #1;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule